// File: doc/BRIEF.md
# First/Next Error Logging Register

This block keeps a record of which hardware errors occurred and in what order. Four error sources each present a one-cycle strobe, alongside the ECC checkbits and the transaction identity (transaction ID and data chunk) of the access involved. The first error seen while the log is empty is written into a first-error status word, and its data is frozen into two read-only capture registers. Any error that arrives after that, while the first-error word still holds a bit, is recorded in a next-error status word. The capture data is not touched by those later errors.

Software reads the four registers through a one-cycle read/write port and clears status bits by writing ones to the first-error word. One such write clears the chosen bits in both status words. A collision bit flags a clearing write and a hardware error that land in the same cycle. In that case the captured data may not belong to the error now shown in the first-error word. Bus decoding, ECC generation and the checkers that raise the strobes sit outside the block.

Register map (on `reg_addr`): 0 is the first-error status, 1 is the next-error status, 2 is the ECC capture, and 3 is the transaction capture.

Top module: `err_first_next_log`

## Requirements
- R1: After a synchronous active-high reset, all four registers read as zero.
- R2: A strobe on `err_strobe[i]` sets bit 27+i of the first-error word. Source 0 is the length-field mismatch, 1 is the write-data protocol error, 2 is the ready/busy handshake error and 3 is the private-bus receive length error. When bits 30:27 are all clear, every strobe of that cycle is recorded together in the first-error word.
- R3: While any of bits 30:27 of the first-error word is set, new strobes set the same bit positions in the next-error word and leave the first-error word unchanged.
- R4: The capture registers load only in a cycle where the first-error word goes from empty to holding a strobe. The ECC capture holds the checkbits in bits 7:0. The transaction capture holds the ID in bits 15:9, the chunk in bits 8:6, and zeros in bits 5:0.
- R5: Writing to address 0 clears each of bits 30:27 written as 1 in both the first-error and next-error words. Bits written as 0 have no effect.
- R6: Bit 31 of the first-error word is set when a write to address 0 with a 1 in bits 30:27 coincides with any strobe and the first-error word is left non-empty. Writing 1 to bit 31 clears it.
- R7: Bit 31 is never set while bits 30:27 are all clear. It drops by itself in the cycle those bits become empty.
- R8: Bits 26:0 of both status words, and bit 31 of the next-error word, always read as zero.
- R9: `reg_rdata` is updated at the clock edge that samples `reg_rd`. It shows the register as it stood before any write or strobe of that same cycle.
- R10: Writes to addresses 1, 2 and 3 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_strobe | input | 4 | One-cycle error strobes, one per source |
| err_ecc | input | 8 | ECC checkbits of the erring access |
| err_txn_id | input | 7 | Transaction ID of the erring access |
| err_chunk | input | 3 | Failing data chunk of the erring access |
| reg_addr | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ones clear) |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |

## Verification
The properties assume that the error strobes and the register port are driven only by the clock domain of the block. They also assume that the strobe data fields are valid whenever a strobe is high, and that the read strobe stays low while reset is asserted. The bench drives every input at the falling edge and holds all strobes and port controls low between operations. Each collision is built on purpose by putting a strobe and a clearing write into the same stimulus cycle, so no cycle carries any other overlap the properties did not expect.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

  typedef enum logic [1:0] {
    SEL_FIRST = 2'd0,
    SEL_NEXT  = 2'd1,
    SEL_ECC   = 2'd2,
    SEL_TXN   = 2'd3
  } reg_sel_e;

  typedef enum int {
    SRC_LEN_MISMATCH = 0,
    SRC_WDATA_PROTO  = 1,
    SRC_HANDSHAKE    = 2,
    SRC_RX_LENGTH    = 3
  } err_src_e;

endpackage

// File: rtl/err_status_core.sv
module err_status_core #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] hw_err,
  input  logic [NUM_SRC-1:0] clr_mask,
  input  logic               clr_coll,
  output logic [NUM_SRC-1:0] first_bits,
  output logic               first_coll,
  output logic [NUM_SRC-1:0] next_bits,
  output logic               load_capture
);

  logic               occupied;
  logic               collision;
  logic [NUM_SRC-1:0] first_nx;
  logic [NUM_SRC-1:0] next_nx;
  logic               coll_nx;

  assign occupied  = |first_bits;
  assign collision = (|clr_mask) && (|hw_err);

  always_comb begin
    if (occupied) begin
      first_nx     = first_bits & ~clr_mask;
      next_nx      = (next_bits & ~clr_mask) | hw_err;
      load_capture = 1'b0;
    end else begin
      first_nx     = hw_err;
      next_nx      = next_bits & ~clr_mask;
      load_capture = |hw_err;
    end
    coll_nx = (|first_nx) && ((first_coll && !clr_coll) || collision);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_bits <= '0;
      next_bits  <= '0;
      first_coll <= 1'b0;
    end else begin
      first_bits <= first_nx;
      next_bits  <= next_nx;
      first_coll <= coll_nx;
    end
  end

endmodule

// File: rtl/err_capture.sv
module err_capture #(
  parameter int ECC_W = 8,
  parameter int ID_W  = 7,
  parameter int CH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ECC_W-1:0] ecc_in,
  input  logic [ID_W-1:0]  id_in,
  input  logic [CH_W-1:0]  ch_in,
  output logic [ECC_W-1:0] ecc_q,
  output logic [ID_W-1:0]  id_q,
  output logic [CH_W-1:0]  ch_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_q <= '0;
      id_q  <= '0;
      ch_q  <= '0;
    end else if (load) begin
      ecc_q <= ecc_in;
      id_q  <= id_in;
      ch_q  <= ch_in;
    end
  end

endmodule

// File: rtl/err_read_port.sv
module err_read_port
  import err_log_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int NUM_SRC  = 4,
  parameter int SRC_LSB  = 27,
  parameter int COLL_BIT = 31,
  parameter int ECC_W    = 8,
  parameter int ID_W     = 7,
  parameter int CH_W     = 3,
  parameter int TXN_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_SRC-1:0] first_bits,
  input  logic               first_coll,
  input  logic [NUM_SRC-1:0] next_bits,
  input  logic [ECC_W-1:0]   ecc_q,
  input  logic [ID_W-1:0]    id_q,
  input  logic [CH_W-1:0]    ch_q,
  output logic [DATA_W-1:0]  rdata
);

  localparam int CH_LSB = TXN_W - ID_W - CH_W;
  localparam int ID_LSB = CH_LSB + CH_W;

  logic [DATA_W-1:0] w_first, w_next, w_ecc, w_txn, w_sel;

  always_comb begin
    w_first = '0;
    w_first[SRC_LSB +: NUM_SRC] = first_bits;
    w_first[COLL_BIT] = first_coll;
    w_next = '0;
    w_next[SRC_LSB +: NUM_SRC] = next_bits;
    w_ecc = '0;
    w_ecc[ECC_W-1:0] = ecc_q;
    w_txn = '0;
    w_txn[CH_LSB +: CH_W] = ch_q;
    w_txn[ID_LSB +: ID_W] = id_q;
    if (rd_addr == ADDR_W'(SEL_FIRST))     w_sel = w_first;
    else if (rd_addr == ADDR_W'(SEL_NEXT)) w_sel = w_next;
    else if (rd_addr == ADDR_W'(SEL_ECC))  w_sel = w_ecc;
    else if (rd_addr == ADDR_W'(SEL_TXN))  w_sel = w_txn;
    else                                   w_sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= w_sel;
  end

endmodule

// File: rtl/err_first_next_log.sv
module err_first_next_log
  import err_log_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int SRC_LSB  = 27,
  parameter int COLL_BIT = 31,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int ECC_W    = 8,
  parameter int ID_W     = 7,
  parameter int CH_W     = 3,
  parameter int TXN_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] err_strobe,
  input  logic [ECC_W-1:0]   err_ecc,
  input  logic [ID_W-1:0]    err_txn_id,
  input  logic [CH_W-1:0]    err_chunk,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_rd,
  output logic [DATA_W-1:0]  reg_rdata
);

  logic               wr_first;
  logic [NUM_SRC-1:0] clr_mask;
  logic               clr_coll;
  logic [NUM_SRC-1:0] first_bits;
  logic               first_coll;
  logic [NUM_SRC-1:0] next_bits;
  logic               load_capture;
  logic [ECC_W-1:0]   ecc_q;
  logic [ID_W-1:0]    id_q;
  logic [CH_W-1:0]    ch_q;
  logic               unused_wdata;

  assign wr_first     = reg_wr && (reg_addr == ADDR_W'(SEL_FIRST));
  assign clr_mask     = wr_first ? reg_wdata[SRC_LSB +: NUM_SRC] : '0;
  assign clr_coll     = wr_first && reg_wdata[COLL_BIT];
  assign unused_wdata = ^reg_wdata;

  err_status_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk          (clk),
    .rst          (rst),
    .hw_err       (err_strobe),
    .clr_mask     (clr_mask),
    .clr_coll     (clr_coll),
    .first_bits   (first_bits),
    .first_coll   (first_coll),
    .next_bits    (next_bits),
    .load_capture (load_capture)
  );

  err_capture #(.ECC_W(ECC_W), .ID_W(ID_W), .CH_W(CH_W)) u_capt (
    .clk    (clk),
    .rst    (rst),
    .load   (load_capture),
    .ecc_in (err_ecc),
    .id_in  (err_txn_id),
    .ch_in  (err_chunk),
    .ecc_q  (ecc_q),
    .id_q   (id_q),
    .ch_q   (ch_q)
  );

  err_read_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB),
    .COLL_BIT(COLL_BIT), .ECC_W(ECC_W), .ID_W(ID_W), .CH_W(CH_W), .TXN_W(TXN_W)
  ) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (reg_rd),
    .rd_addr    (reg_addr),
    .first_bits (first_bits),
    .first_coll (first_coll),
    .next_bits  (next_bits),
    .ecc_q      (ecc_q),
    .id_q       (id_q),
    .ch_q       (ch_q),
    .rdata      (reg_rdata)
  );

endmodule

// File: rtl/err_first_next_log_chk.sv
module err_first_next_log_chk #(
  parameter int NUM_SRC  = 4,
  parameter int SRC_LSB  = 27,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int ECC_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] err_strobe,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [NUM_SRC-1:0] first_bits,
  input logic               first_coll,
  input logic [NUM_SRC-1:0] next_bits,
  input logic [ECC_W-1:0]   ecc_q
);

  logic               occ;
  logic               clr_wr;
  logic [NUM_SRC-1:0] wmask;

  assign occ    = |first_bits;
  assign clr_wr = reg_wr && (reg_addr == '0);
  assign wmask  = reg_wdata[SRC_LSB +: NUM_SRC];

  AST_FIRST_LOADS_ALL: assert property (@(posedge clk) disable iff (rst)
    (!occ && |err_strobe) |=> (first_bits == $past(err_strobe))); // R2
  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (rst)
    (occ && !clr_wr) |=> $stable(first_bits)); // R3
  AST_NEXT_ONLY_WHEN_OCC: assert property (@(posedge clk) disable iff (rst)
    (!occ) |=> ((next_bits & ~$past(next_bits)) == '0)); // R3
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    occ |=> $stable(ecc_q)); // R4
  AST_W1C_BOTH: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && occ) |=> (((first_bits | next_bits) & $past(wmask) & ~$past(err_strobe)) == '0)); // R5
  AST_COLL_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && |wmask && |err_strobe && !occ) |=> first_coll); // R6
  AST_COLL_NOT_ALONE: assert property (@(posedge clk) disable iff (rst)
    first_coll |-> occ); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_addr[ADDR_W-1]) |=> (reg_rdata[SRC_LSB-1:0] == '0)); // R8

endmodule

bind err_first_next_log err_first_next_log_chk #(
  .NUM_SRC(NUM_SRC), .SRC_LSB(SRC_LSB), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ECC_W(ECC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .err_strobe (err_strobe),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .first_bits (first_bits),
  .first_coll (first_coll),
  .next_bits  (next_bits),
  .ecc_q      (ecc_q)
);

// File: tb/err_first_next_log_bench.sv
`timescale 1ns/1ps
module err_first_next_log_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  err_strobe = '0;
  logic [7:0]  err_ecc = '0;
  logic [6:0]  err_txn_id = '0;
  logic [2:0]  err_chunk = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad   = 0;

  logic [3:0] m_first = '0;
  logic       m_coll  = 1'b0;
  logic [3:0] m_next  = '0;
  logic [7:0] m_ecc   = '0;
  logic [6:0] m_id    = '0;
  logic [2:0] m_ch    = '0;

  always #2 clk = ~clk;

  err_first_next_log u_err_first_next_log (
    .clk(clk), .rst(rst), .err_strobe(err_strobe), .err_ecc(err_ecc),
    .err_txn_id(err_txn_id), .err_chunk(err_chunk), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] exp_word(input logic [1:0] a);
    case (a)
      2'd0:    return {m_coll, m_first, 27'd0};
      2'd1:    return {1'b0, m_next, 27'd0};
      2'd2:    return {24'd0, m_ecc};
      default: return {16'd0, m_id, m_ch, 6'd0};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic [7:0] e, input logic [6:0] id,
                      input logic [2:0] ch, input logic w, input logic [1:0] a,
                      input logic [31:0] wd, input logic r, input string tag);
    logic [31:0] exp;
    logic [3:0]  clr, nf, nn;
    logic        cc, col;
    @(negedge clk);
    err_strobe = s; err_ecc = e; err_txn_id = id; err_chunk = ch;
    reg_wr = w; reg_addr = a; reg_wdata = wd; reg_rd = r;
    exp = exp_word(a);
    clr = (w && a == 2'd0) ? wd[30:27] : 4'd0;
    cc  = w && a == 2'd0 && wd[31];
    col = (|clr) && (|s);
    if (|m_first) begin
      nf = m_first & ~clr;
      nn = (m_next & ~clr) | s;
    end else begin
      nf = s;
      nn = m_next & ~clr;
      if (|s) begin m_ecc = e; m_id = id; m_ch = ch; end
    end
    m_coll  = (|nf) && ((m_coll && !cc) || col);
    m_first = nf;
    m_next  = nn;
    @(negedge clk);
    err_strobe = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    if (r) check(tag, reg_rdata, exp);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b0, a, 32'd0, 1'b1, tag);
  endtask

  task automatic clear_all();
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, "");
  endtask

  task automatic fire(input logic [3:0] s, input int k);
    step(s, 8'(k * 13 + 5), 7'(k * 9 + 1), 3'(k), 1'b0, 2'd0, 32'd0, 1'b0, "");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");

    // R2 R3 R4: sweep first pattern p against follow-up pattern q
    for (int p = 1; p < 16; p++) begin
      for (int q = 0; q < 16; q++) begin
        clear_all();
        fire(4'(p), p);
        if (q == 0) begin
          rd(2'd0, "R2");
          rd(2'd2, "R4");
          rd(2'd3, "R4");
        end
        fire(4'(q), p + q + 40);
        rd(2'd1, "R3");
        rd(2'd0, "R3");
        rd(2'd2, "R4");
        rd(2'd3, "R4");
      end
    end

    // R5: zero write and partial clear on both words
    clear_all();
    fire(4'b0101, 3);
    fire(4'b1110, 4);
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'd0, 1'b0, "");
    rd(2'd0, "R5"); rd(2'd1, "R5");
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'h3000_0000, 1'b0, "");
    rd(2'd0, "R5"); rd(2'd1, "R5");

    // R10: writes to other addresses ignored
    for (int a = 1; a < 4; a++)
      step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'(a), 32'hFFFF_FFFF, 1'b0, "");
    for (int a = 0; a < 4; a++) rd(2'(a), "R10");

    // R6: collision on occupied word, then auto-drop R7
    clear_all();
    fire(4'b0011, 6);
    step(4'b0100, 8'hAA, 7'h11, 3'd2, 1'b1, 2'd0, 32'h0800_0000, 1'b0, "");
    rd(2'd0, "R6"); rd(2'd1, "R6"); rd(2'd2, "R6");
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'h1000_0000, 1'b0, "");
    rd(2'd0, "R7");

    // R6: collision on empty word, then clear by writing bit 31
    clear_all();
    step(4'b1000, 8'h5C, 7'h33, 3'd7, 1'b1, 2'd0, 32'h4000_0000, 1'b0, "");
    rd(2'd0, "R6"); rd(2'd3, "R6");
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'h8000_0000, 1'b0, "");
    rd(2'd0, "R6");

    // R7: collision whose clear empties the first word
    clear_all();
    fire(4'b0001, 8);
    step(4'b0010, 8'h01, 7'h02, 3'd3, 1'b1, 2'd0, 32'h0800_0000, 1'b0, "");
    rd(2'd0, "R7"); rd(2'd1, "R7");

    // R8: reserved bits with every source set in both words
    clear_all();
    fire(4'hF, 9);
    fire(4'hF, 10);
    rd(2'd0, "R8"); rd(2'd1, "R8");

    // R9: read in the same cycle as a clear and as a strobe
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b1, "R9");
    rd(2'd0, "R9");
    step(4'b0001, 8'h77, 7'h44, 3'd1, 1'b0, 2'd0, 32'd0, 1'b1, "R9");
    step(4'd0, 8'd0, 7'd0, 3'd0, 1'b0, 2'd2, 32'd0, 1'b1, "R9");

    finish_run();
  end

endmodule